// File: doc/BRIEF.md
# Signed Four-Bit ALU with Switch and Seven-Segment Front End

This block is a purely combinational arithmetic-logic unit for two 4-bit two's-complement operands, wrapped in a board-level front end. The front end takes a two-bit operation code and both operands from a ten-bit bank of slide switches. It returns the 4-bit result together with a carry-out flag and a signed-overflow flag. The four operations are addition, subtraction, bitwise AND and bitwise XOR.

The wrapper shows the two operands and the result as signed decimal values on three pairs of active-low seven-segment digits. In each pair the upper digit is blank or shows a minus sign, and the lower digit shows the magnitude. The raw result bits and both flags also appear on a row of LEDs. There is no clock and no state. Every output settles from the switches through combinational logic alone. The block has no state machine, so it has no states or transitions to name.

Top module: `sw_alu_board`

## Requirements
- R1: The switch bank splits into fields as follows: sw[9:8] is the operation code, sw[7:4] is operand A and sw[3:0] is operand B. Each operand is a 4-bit two's-complement value in the range -8 to 7.
- R2: Code 00 adds the operands. Z = (A + B) mod 16, and carry is bit 4 of the unsigned 5-bit sum.
- R3: Code 01 subtracts B from A as A + ~B + 1. Z = (A - B) mod 16, and carry is 1 exactly when A >= B taken as unsigned values, so carry = 1 means no borrow.
- R4: For codes 00 and 01, overflow is 1 exactly when the true signed result lies outside -8..7.
- R5: Code 10 gives Z = A AND B, and code 11 gives Z = A XOR B. For both codes, carry and overflow are 0.
- R6: The LED outputs are ledr[3:0] = Z, ledr[8] = carry and ledr[9] = overflow. ledr[7:4] are always 0.
- R7: The digit pairs are assigned as follows: hex5/hex4 show A, hex3/hex2 show B and hex1/hex0 show Z, each read as a signed value. The upper digit is the minus glyph 7'h3F when the value is negative and blank 7'h7F otherwise. The lower digit shows the absolute value, so -8 shows a minus sign and the glyph for 8.
- R8: Segments are active-low, with bit 0 = segment a through bit 6 = segment g. The magnitude glyphs are 0:40, 1:79, 2:24, 3:30, 4:19, 5:12, 6:02, 7:78, 8:00 (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw   | input  | 10 | Slide switches: operation code, operand A, operand B |
| hex5 | output | 7  | Sign digit of A |
| hex4 | output | 7  | Magnitude digit of A |
| hex3 | output | 7  | Sign digit of B |
| hex2 | output | 7  | Magnitude digit of B |
| hex1 | output | 7  | Sign digit of Z |
| hex0 | output | 7  | Magnitude digit of Z |
| ledr | output | 10 | Z bits, carry-out, overflow |

## Verification
The assertions check four relations whenever the switches change:
- the sign digits follow the top bits of A, B and Z;
- the logic operations keep both flags low;
- an overflow on addition always pairs operands of equal sign with a result of the other sign;
- subtracting zero never borrows.

Only the bench scenarios show that the result values, the carry on every operand pair and the magnitude glyphs are exactly right. They also cover the boundary cases that include -8 and the specific table vectors.

// File: rtl/alu_disp_pkg.sv
package alu_disp_pkg;
    localparam int ALU_W   = 4;
    localparam int OPC_W   = 2;
    localparam int SW_W    = OPC_W + 2 * ALU_W;
    localparam int SEG_W   = 7;
    localparam int LED_W   = 10;
    localparam int LED_CY  = 8;
    localparam int LED_OV  = 9;
    localparam int N_SHOWN = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic [ALU_W-1:0] z;
        logic             carry;
        logic             ovf;
    } alu_res_t;

    localparam logic [SEG_W-1:0] GLYPH_BLANK = 7'h7F;
    localparam logic [SEG_W-1:0] GLYPH_MINUS = 7'h3F;
endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_disp_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   z,
    output logic           carry,
    output logic           ovf
);
    logic         is_sub;
    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic         arith_ovf;

    assign is_sub    = (op == OP_SUB);
    assign b_eff     = is_sub ? ~b : b;
    assign sum       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
    assign arith_ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: begin
                z     = sum[W-1:0];
                carry = sum[W];
                ovf   = arith_ovf;
            end
            OP_AND: begin
                z     = a & b;
                carry = 1'b0;
                ovf   = 1'b0;
            end
            OP_XOR: begin
                z     = a ^ b;
                carry = 1'b0;
                ovf   = 1'b0;
            end
            default: begin
                z     = '0;
                carry = 1'b0;
                ovf   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seg_glyph.sv
module seg_glyph
    import alu_disp_pkg::*;
#(
    parameter int DW = 5
) (
    input  logic [DW-1:0]    digit,
    output logic [SEG_W-1:0] seg_n
);
    always_comb begin
        unique case (digit)
            DW'(0):  seg_n = 7'h40;
            DW'(1):  seg_n = 7'h79;
            DW'(2):  seg_n = 7'h24;
            DW'(3):  seg_n = 7'h30;
            DW'(4):  seg_n = 7'h19;
            DW'(5):  seg_n = 7'h12;
            DW'(6):  seg_n = 7'h02;
            DW'(7):  seg_n = 7'h78;
            DW'(8):  seg_n = 7'h00;
            DW'(9):  seg_n = 7'h10;
            default: seg_n = GLYPH_BLANK;
        endcase
    end
endmodule

// File: rtl/signed_digit_pair.sv
module signed_digit_pair
    import alu_disp_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0]     val,
    output logic [SEG_W-1:0] sign_seg,
    output logic [SEG_W-1:0] mag_seg
);
    localparam int MW = W + 1;

    logic          neg;
    logic [MW-1:0] ext;
    logic [MW-1:0] mag;

    assign neg      = val[W-1];
    assign ext      = {val[W-1], val};
    assign mag      = neg ? (~ext + MW'(1)) : ext;
    assign sign_seg = neg ? GLYPH_MINUS : GLYPH_BLANK;

    seg_glyph #(.DW(MW)) u_glyph (
        .digit (mag),
        .seg_n (mag_seg)
    );
endmodule

// File: rtl/sw_alu_board.sv
module sw_alu_board
    import alu_disp_pkg::*;
(
    input  logic [SW_W-1:0]  sw,
    output logic [SEG_W-1:0] hex5,
    output logic [SEG_W-1:0] hex4,
    output logic [SEG_W-1:0] hex3,
    output logic [SEG_W-1:0] hex2,
    output logic [SEG_W-1:0] hex1,
    output logic [SEG_W-1:0] hex0,
    output logic [LED_W-1:0] ledr
);
    alu_op_e          op;
    logic [ALU_W-1:0] opa;
    logic [ALU_W-1:0] opb;
    alu_res_t         res;

    assign op  = alu_op_e'(sw[SW_W-1 -: OPC_W]);
    assign opa = sw[2*ALU_W-1 -: ALU_W];
    assign opb = sw[ALU_W-1:0];

    alu_core #(.W(ALU_W)) u_core (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .z     (res.z),
        .carry (res.carry),
        .ovf   (res.ovf)
    );

    logic [ALU_W-1:0] shown    [N_SHOWN];
    logic [SEG_W-1:0] sign_seg [N_SHOWN];
    logic [SEG_W-1:0] mag_seg  [N_SHOWN];

    assign shown[0] = res.z;
    assign shown[1] = opb;
    assign shown[2] = opa;

    for (genvar gi = 0; gi < N_SHOWN; gi++) begin : g_pair
        signed_digit_pair #(.W(ALU_W)) u_pair (
            .val      (shown[gi]),
            .sign_seg (sign_seg[gi]),
            .mag_seg  (mag_seg[gi])
        );
    end

    assign hex1 = sign_seg[0];
    assign hex0 = mag_seg[0];
    assign hex3 = sign_seg[1];
    assign hex2 = mag_seg[1];
    assign hex5 = sign_seg[2];
    assign hex4 = mag_seg[2];

    always_comb begin
        ledr              = '0;
        ledr[ALU_W-1:0]   = res.z;
        ledr[LED_CY]      = res.carry;
        ledr[LED_OV]      = res.ovf;
    end
endmodule

// File: rtl/alu_board_chk.sv
module alu_board_chk
    import alu_disp_pkg::*;
(
    input logic [SW_W-1:0]  sw,
    input logic [SEG_W-1:0] hex5,
    input logic [SEG_W-1:0] hex3,
    input logic [SEG_W-1:0] hex1,
    input logic [LED_W-1:0] ledr
);
    always_comb begin
        if (!$isunknown(sw)) begin
            AST_A_SIGN_DIGIT: assert ((hex5 == GLYPH_MINUS) == sw[7]); // R7
            AST_B_SIGN_DIGIT: assert ((hex3 == GLYPH_MINUS) == sw[3]); // R7
            AST_Z_SIGN_DIGIT: assert ((hex1 == GLYPH_MINUS) == ledr[3]); // R7
            AST_LOGIC_NO_FLAGS: assert (!sw[9] || (!ledr[LED_CY] && !ledr[LED_OV])); // R5
            AST_ADD_OVF_SIGNS: assert (!(sw[9:8] == 2'b00 && ledr[LED_OV])
                || (sw[7] == sw[3] && ledr[3] != sw[7])); // R4
            AST_SUB_ZERO_NO_BORROW: assert (!(sw[9:8] == 2'b01 && sw[3:0] == 4'd0)
                || ledr[LED_CY]); // R3
        end
    end
endmodule

bind sw_alu_board alu_board_chk u_chk (
    .sw   (sw),
    .hex5 (hex5),
    .hex3 (hex3),
    .hex1 (hex1),
    .ledr (ledr)
);

// File: tb/sim_sw_alu_board.sv
`timescale 1ns/1ps
module sim_sw_alu_board;
    logic       clk = 1'b0;
    logic [9:0] sw;
    logic [6:0] hex5, hex4, hex3, hex2, hex1, hex0;
    logic [9:0] ledr;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sw_alu_board u0 (
        .sw(sw), .hex5(hex5), .hex4(hex4), .hex3(hex3),
        .hex2(hex2), .hex1(hex1), .hex0(hex0), .ledr(ledr)
    );

    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24;
            3: return 7'h30; 4: return 7'h19; 5: return 7'h12;
            6: return 7'h02; 7: return 7'h78; 8: return 7'h00;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic int sval(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (sw=%b)", req, act, exp, sw);
        end
    endtask

    task automatic apply(input logic [9:0] v);
        @(negedge clk);
        sw = v;
        @(posedge clk);
        #1;
    endtask

    task automatic check_pair(input string req, input logic [6:0] hi,
                              input logic [6:0] lo, input int v);
        check(req, hi, (v < 0) ? 7'h3F : 7'h7F);
        check(req, lo, glyph((v < 0) ? -v : v));
    endtask

    task automatic check_all(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b);
        int au, bu, sa, sb, t, z, cy, ov;
        au = int'(a); bu = int'(b); sa = sval(a); sb = sval(b);
        cy = 0; ov = 0; t = 0;
        case (op)
            2'b00: begin t = sa + sb; z = (au + bu) & 15; cy = (au + bu > 15) ? 1 : 0; end
            2'b01: begin t = sa - sb; z = (au - bu) & 15; cy = (au >= bu) ? 1 : 0; end
            2'b10: z = au & bu;
            default: z = au ^ bu;
        endcase
        if (op[1] == 1'b0) ov = (t > 7 || t < -8) ? 1 : 0;
        apply({op, a, b});
        check(op == 2'b00 ? "R2 result" : op == 2'b01 ? "R3 result" : "R5 result",
              ledr[3:0], z);
        check(op[1] ? "R5 carry" : (op[0] ? "R3 carry" : "R2 carry"), ledr[8], cy);
        check(op[1] ? "R5 overflow" : "R4 overflow", ledr[9], ov);
        check("R6 unused leds", ledr[7:4], 0);
        check_pair("R7 A pair", hex5, hex4, sa);
        check_pair("R7 B pair", hex3, hex2, sb);
        check_pair("R7 Z pair", hex1, hex0, sval(z[3:0]));
    endtask

    task automatic t_idle_state;
        apply(10'd0);
        check("R7 idle A sign", hex5, 7'h7F);
        check("R8 idle A zero", hex4, 7'h40);
        check("R8 idle Z zero", hex0, 7'h40);
        check("R6 idle leds", ledr, 0);
    endtask

    task automatic t_table_vectors;
        logic [7:0] pairs [4];
        pairs[0] = 8'b0101_1100; pairs[1] = 8'b1111_0101;
        pairs[2] = 8'b1010_0011; pairs[3] = 8'b1101_1010;
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 4; i++)
                check_all(op[1:0], pairs[i][7:4], pairs[i][3:0]);
    endtask

    task automatic t_field_split;
        // R1: only A=3 set, B=0, add -> Z=3, A shown as 3, B as 0
        apply({2'b00, 4'd3, 4'd0});
        check("R1 A field", hex4, 7'h30);
        check("R1 B field", hex2, 7'h40);
        apply({2'b10, 4'hF, 4'h6});
        check("R1 opcode field AND", ledr[3:0], 6);
    endtask

    task automatic t_corner_cases;
        apply({2'b00, 4'h7, 4'h1});   // 7+1 overflows to -8
        check("R4 7+1 ovf", ledr[9], 1);
        check("R7 -8 sign", hex1, 7'h3F);
        check("R8 -8 mag", hex0, 7'h00);
        apply({2'b01, 4'h8, 4'h1});   // -8-1 overflows
        check("R4 -8-1 ovf", ledr[9], 1);
        check("R3 -8-1 carry", ledr[8], 1);
        apply({2'b01, 4'h0, 4'h8});   // 0-(-8) overflows, borrow
        check("R4 0+8 ovf", ledr[9], 1);
        check("R3 borrow", ledr[8], 0);
        apply({2'b11, 4'hF, 4'hF});
        check("R5 xor flags", {ledr[9], ledr[8]}, 0);
    endtask

    task automatic t_full_sweep;
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    check_all(op[1:0], a[3:0], b[3:0]);
    endtask

    initial begin
        sw = '0;
        t_idle_state();
        t_field_split();
        t_table_vectors();
        t_corner_cases();
        t_full_sweep();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule